// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The unit keeps a free-running 32-bit time counter and records time-stamped events in a 16-entry hardware queue. Software reads the queue head and discards entries through a small word-addressed register bus. Events come from six kinds of source:

- a software push register;
- the counter passing its half-way point and wrapping to zero;
- four external push pins;
- receive and transmit strobes from an Ethernet port, which carry a PTP message type, a sequence ID and a port number.

Several sources can fire in the same clock cycle. Each source owns one staging slot. The slots drain into the queue one entry per cycle, in a fixed priority order. A level interrupt tells software that entries are waiting.

Software reads the head entry through two words. The low word holds the timestamp. The high word packs the port or pin number, the event kind, the message type and the sequence ID. Software then writes the discard register to reach the next entry. When the queue is full, new entries are dropped and a sticky overflow flag records the loss.

Top module: `tsu_capture_top`

## Requirements
- R1: After reset the following hold: control, interrupt enable, status, load value and reference select read 0; the head words read 0; `irq` is low. Word 0 (identification) always reads the `ID_WORD` parameter.
- R2: While control bit 0 is 1, the counter advances by one every cycle; while it is 0, the counter holds. Writing 1 to bit 0 of word 5 copies the load-value register (word 4) into the counter.
- R3: Writing 1 to bit 0 of word 3 queues a kind-0 event. Its stamp is the counter value in the cycle the write is presented.
- R4: When the counter steps from 0xFFFFFFFF, a kind-1 event with stamp 0 is queued. When it steps from 0x7FFFFFFF, a kind-2 event with stamp 0x80000000 is queued. A load never produces either event.
- R5: Each push pin passes through a two-flop synchroniser before its rising edge is detected. A detected edge queues a kind-3 event whose port field is the pin number (1..4). Control bits 8..11 enable pins 1..4; a rising edge on a disabled pin is ignored. The pin's stamp is 2 greater than the stamp of a software push presented in the same cycle as the pin rises.
- R6: A receive strobe queues a kind-4 event and a transmit strobe queues a kind-5 event. Each carries its message type, sequence ID and port, with the counter value of the strobe cycle as its stamp.
- R7: Word 14 reads the head entry as {3'b0, port[28:24], kind[23:20], message[19:16], sequence[15:0]}. Word 13 reads the head timestamp. Both read 0 when the queue is empty.
- R8: Events from one cycle enter the queue in this order: wrap, half, software push, pins 1..4, receive, transmit.
- R9: The queue keeps 16 entries in arrival order. Writing 1 to bit 0 of word 12 discards the head entry. A discard on an empty queue has no effect.
- R10: An entry that arrives while the queue holds 16 is dropped and the stored entries are kept. The drop sets a sticky overflow flag at bit 1 of word 8. Writing 1 to that bit clears the flag.
- R11: Bit 0 of word 8 is 1 while the queue is non-empty or control bit 1 (interrupt test) is set. Bit 0 of word 9 equals that bit ANDed with bit 0 of word 10, and `irq` follows word 9 bit 0.
- R12: While control bit 0 is 0, no source queues an event.
- R13: The low bits of word 2 are stored and driven on `ref_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_pin | input | N_PINS | Asynchronous push pins |
| rx_stb | input | 1 | Receive event strobe |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| rx_port | input | 5 | Receive port number |
| tx_stb | input | 1 | Transmit event strobe |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| tx_port | input | 5 | Transmit port number |
| irq | output | 1 | Level interrupt |
| ref_sel | output | REFSEL_W | Reference clock select value |

## Verification
The assertions assume that no source fires again while its staging slot still waits behind higher-priority slots. Such a collision drops the event and sets the overflow flag, and the priority order then no longer describes arrival order. The stimulus leaves at least three idle cycles after every burst of simultaneous events. It also starts the counter near its wrap and half points only through loads, so wrap and half events land on known cycles.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int STAMP_W = 32;

  typedef enum logic [3:0] {
    EV_SWPUSH = 4'd0,
    EV_WRAP   = 4'd1,
    EV_HALF   = 4'd2,
    EV_PIN    = 4'd3,
    EV_RXPKT  = 4'd4,
    EV_TXPKT  = 4'd5
  } ev_kind_e;

  typedef struct packed {
    logic [4:0]         port;
    ev_kind_e           kind;
    logic [3:0]         msg;
    logic [15:0]        seq;
    logic [STAMP_W-1:0] stamp;
  } ev_rec_t;

  // word indices of the register map
  localparam logic [3:0] A_ID     = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_REFSEL = 4'd2;
  localparam logic [3:0] A_PUSH   = 4'd3;
  localparam logic [3:0] A_LDVAL  = 4'd4;
  localparam logic [3:0] A_LDEN   = 4'd5;
  localparam logic [3:0] A_RAW    = 4'd8;
  localparam logic [3:0] A_MASK   = 4'd9;
  localparam logic [3:0] A_IEN    = 4'd10;
  localparam logic [3:0] A_POP    = 4'd12;
  localparam logic [3:0] A_EVLO   = 4'd13;
  localparam logic [3:0] A_EVHI   = 4'd14;

  function automatic logic [31:0] pack_hi(input ev_rec_t r);
    return {3'b000, r.port, r.kind, r.msg, r.seq};
  endfunction

  function automatic logic at_wrap(input logic [STAMP_W-1:0] c);
    return &c;
  endfunction

  function automatic logic at_half(input logic [STAMP_W-1:0] c);
    return c == {1'b0, {(STAMP_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/tsu_counter.sv
module tsu_counter import tsu_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               load,
  input  logic [STAMP_W-1:0] load_val,
  output logic [STAMP_W-1:0] cnt,
  output logic               wrap_evt,
  output logic               half_evt
);
  logic stepping;
  assign stepping = run && !load;
  assign wrap_evt = stepping && at_wrap(cnt);
  assign half_evt = stepping && at_half(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (run)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsu_pin_edge.sv
module tsu_pin_edge #(
  parameter int N_PINS = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin,
  input  logic [N_PINS-1:0] pin_en,
  output logic [N_PINS-1:0] rise
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pin[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[g] = s2 && !s3 && pin_en[g];
  end
endmodule

// File: rtl/tsu_stager.sv
module tsu_stager import tsu_pkg::*; #(
  parameter int N_SRC = 9
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  ev_rec_t          in_rec [N_SRC],
  output logic             out_vld,
  output ev_rec_t          out_rec,
  output logic [N_SRC-1:0] grant,
  output logic             collide
);
  logic [N_SRC-1:0] pend;
  ev_rec_t          slot [N_SRC];
  logic [N_SRC-1:0] takes;

  // lowest index wins: it is the highest priority
  assign grant   = pend & (~pend + 1'b1);
  assign out_vld = |pend;
  assign takes   = req & (~pend | grant);
  assign collide = |(req & ~takes);

  always_comb begin
    out_rec = '0;
    for (int i = 0; i < N_SRC; i++)
      if (grant[i]) out_rec = slot[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~grant) | takes;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SRC; i++)
      if (takes[i]) slot[i] <= in_rec[i];
  end
endmodule

// File: rtl/tsu_evq.sv
module tsu_evq import tsu_pkg::*; #(
  parameter int DEPTH = 16
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  ev_rec_t                    wr_rec,
  input  logic                       pop,
  output ev_rec_t                    head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  ev_rec_t       mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic          full, accept, take;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign accept = wr && !full;
  assign drop   = wr && full;
  assign take   = pop && !empty;
  assign head   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (accept) wp <= adv(wp);
      if (take)   rp <= adv(rp);
      count <= count + CW'(accept) - CW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_rec;
  end
endmodule

// File: rtl/tsu_capture_top.sv
module tsu_capture_top import tsu_pkg::*; #(
  parameter int          DEPTH    = 16,
  parameter int          N_PINS   = 4,
  parameter int          REFSEL_W = 5,
  parameter logic [31:0] ID_WORD  = 32'h4E5A_0103
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [3:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [N_PINS-1:0]   hw_pin,
  input  logic                rx_stb,
  input  logic [3:0]          rx_msg,
  input  logic [15:0]         rx_seq,
  input  logic [4:0]          rx_port,
  input  logic                tx_stb,
  input  logic [3:0]          tx_msg,
  input  logic [15:0]         tx_seq,
  input  logic [4:0]          tx_port,
  output logic                irq,
  output logic [REFSEL_W-1:0] ref_sel
);
  localparam int N_SRC    = N_PINS + 5;
  localparam int SRC_WRAP = 0;
  localparam int SRC_HALF = 1;
  localparam int SRC_SW   = 2;
  localparam int SRC_PIN0 = 3;
  localparam int SRC_RX   = N_PINS + 3;
  localparam int SRC_TX   = N_PINS + 4;
  localparam int CW       = $clog2(DEPTH+1);

  // control and configuration registers
  logic                ctl_run, ctl_test, ien, ovf;
  logic [N_PINS-1:0]   pin_en;
  logic [STAMP_W-1:0]  ldval;
  logic [REFSEL_W-1:0] refsel_q;

  // named internal events
  logic                sw_push, load_req, pop_req, ovf_clr, ovf_set;
  logic                wrap_evt, half_evt;
  logic [STAMP_W-1:0]  cnt;
  logic [N_PINS-1:0]   pin_rise;
  logic [N_SRC-1:0]    src_req, grant;
  ev_rec_t             src_rec [N_SRC];
  logic                stage_vld, stage_collide;
  ev_rec_t             stage_rec, head;
  logic [CW-1:0]       q_cnt;
  logic                q_empty, q_drop;
  logic                raw_pend;

  function automatic logic hit(input logic wr, input logic [3:0] a,
                               input logic [3:0] w, input logic b);
    return wr && (a == w) && b;
  endfunction

  assign sw_push  = hit(bus_wr, bus_addr, A_PUSH, bus_wdata[0]) && ctl_run;
  assign load_req = hit(bus_wr, bus_addr, A_LDEN, bus_wdata[0]);
  assign pop_req  = hit(bus_wr, bus_addr, A_POP,  bus_wdata[0]);
  assign ovf_clr  = hit(bus_wr, bus_addr, A_RAW,  bus_wdata[1]);
  assign ovf_set  = q_drop || stage_collide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_run  <= 1'b0;
      ctl_test <= 1'b0;
      pin_en   <= '0;
      ien      <= 1'b0;
      ldval    <= '0;
      refsel_q <= '0;
      ovf      <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) begin
        ctl_run  <= bus_wdata[0];
        ctl_test <= bus_wdata[1];
        pin_en   <= bus_wdata[8 +: N_PINS];
      end
      if (bus_wr && bus_addr == A_IEN)    ien      <= bus_wdata[0];
      if (bus_wr && bus_addr == A_LDVAL)  ldval    <= bus_wdata;
      if (bus_wr && bus_addr == A_REFSEL) refsel_q <= bus_wdata[REFSEL_W-1:0];
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  assign ref_sel = refsel_q;

  tsu_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl_run), .load(load_req),
    .load_val(ldval), .cnt(cnt), .wrap_evt(wrap_evt), .half_evt(half_evt)
  );

  tsu_pin_edge #(.N_PINS(N_PINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin(hw_pin), .pin_en(pin_en), .rise(pin_rise)
  );

  // one record per source; the stamp is the counter value of the cycle
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      src_rec[i]       = '0;
      src_rec[i].stamp = cnt;
    end
    src_rec[SRC_WRAP].kind  = EV_WRAP;
    src_rec[SRC_WRAP].stamp = cnt + 1'b1;
    src_rec[SRC_HALF].kind  = EV_HALF;
    src_rec[SRC_HALF].stamp = cnt + 1'b1;
    src_rec[SRC_SW].kind    = EV_SWPUSH;
    for (int p = 0; p < N_PINS; p++) begin
      src_rec[SRC_PIN0+p].kind = EV_PIN;
      src_rec[SRC_PIN0+p].port = 5'(p + 1);
    end
    src_rec[SRC_RX].kind = EV_RXPKT;
    src_rec[SRC_RX].msg  = rx_msg;
    src_rec[SRC_RX].seq  = rx_seq;
    src_rec[SRC_RX].port = rx_port;
    src_rec[SRC_TX].kind = EV_TXPKT;
    src_rec[SRC_TX].msg  = tx_msg;
    src_rec[SRC_TX].seq  = tx_seq;
    src_rec[SRC_TX].port = tx_port;
  end

  always_comb begin
    src_req = '0;
    src_req[SRC_WRAP] = wrap_evt;
    src_req[SRC_HALF] = half_evt;
    src_req[SRC_SW]   = sw_push;
    src_req[SRC_PIN0 +: N_PINS] = pin_rise & {N_PINS{ctl_run}};
    src_req[SRC_RX]   = rx_stb && ctl_run;
    src_req[SRC_TX]   = tx_stb && ctl_run;
  end

  tsu_stager #(.N_SRC(N_SRC)) u_stage (
    .clk(clk), .rst_n(rst_n), .req(src_req), .in_rec(src_rec),
    .out_vld(stage_vld), .out_rec(stage_rec), .grant(grant),
    .collide(stage_collide)
  );

  tsu_evq #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .wr(stage_vld), .wr_rec(stage_rec),
    .pop(pop_req), .head(head), .count(q_cnt), .empty(q_empty), .drop(q_drop)
  );

  assign raw_pend = !q_empty || ctl_test;
  assign irq      = raw_pend && ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID:     bus_rdata = ID_WORD;
      A_CTRL: begin
        bus_rdata[0]            = ctl_run;
        bus_rdata[1]            = ctl_test;
        bus_rdata[8 +: N_PINS]  = pin_en;
      end
      A_REFSEL: bus_rdata[REFSEL_W-1:0] = refsel_q;
      A_LDVAL:  bus_rdata = ldval;
      A_RAW:    bus_rdata[1:0] = {ovf, raw_pend};
      A_MASK:   bus_rdata[0]   = raw_pend && ien;
      A_IEN:    bus_rdata[0]   = ien;
      A_EVLO:   bus_rdata = q_empty ? '0 : head.stamp;
      A_EVHI:   bus_rdata = q_empty ? '0 : pack_hi(head);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

module tsu_capture_chk #(
  parameter int DEPTH = 16,
  parameter int N_SRC = 9
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wrap_evt,
  input logic [31:0]                cnt,
  input logic [$clog2(DEPTH+1)-1:0] q_cnt,
  input logic                       q_wr,
  input logic                       q_pop,
  input logic                       q_drop,
  input logic                       ovf,
  input logic                       ovf_clr,
  input logic                       irq,
  input logic                       test_bit,
  input logic [N_SRC-1:0]           grant
);
  localparam int CW = $clog2(DEPTH+1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH)); // R9
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == '0 && !q_wr) |=> q_cnt == '0); // R9
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt == 32'd0); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == CW'(DEPTH) && !q_pop) |=> q_cnt == CW'(DEPTH)); // R10
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    q_drop |=> ovf); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (q_cnt != '0 || test_bit)); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
endmodule

bind tsu_capture_top tsu_capture_chk #(.DEPTH(DEPTH), .N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .cnt(cnt), .q_cnt(q_cnt),
  .q_wr(stage_vld), .q_pop(pop_req), .q_drop(q_drop), .ovf(ovf),
  .ovf_clr(ovf_clr), .irq(irq), .test_bit(ctl_test), .grant(grant)
);

// File: tb/tb_tsu_capture_top.sv
`timescale 1ns/1ps
module tb_tsu_capture_top;
  localparam logic [31:0] IDW = 32'h4E5A_0103;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  hw_pin = '0;
  logic        rx_stb = 1'b0, tx_stb = 1'b0;
  logic [3:0]  rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic [4:0]  rx_port = '0, tx_port = '0;
  logic        irq;
  logic [4:0]  ref_sel;

  int total = 0, bad = 0, cyc = 0, c0 = 0, last_m = 0;
  bit done = 0;
  logic [31:0] base_v = '0;
  logic [63:0] mq[$];

  tsu_capture_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_pin(hw_pin),
    .rx_stb(rx_stb), .rx_msg(rx_msg), .rx_seq(rx_seq), .rx_port(rx_port),
    .tx_stb(tx_stb), .tx_msg(tx_msg), .tx_seq(tx_seq), .tx_port(tx_port),
    .irq(irq), .ref_sel(ref_sel)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_hi(input logic [4:0] port, input logic [3:0] kind,
                                        input logic [3:0] msg, input logic [15:0] seq);
    return (32'(port) << 24) | (32'(kind) << 20) | (32'(msg) << 16) | 32'(seq);
  endfunction

  function automatic logic [31:0] stampf(input int m);
    return base_v + 32'(m - c0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; last_m = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic load(input logic [31:0] v);
    wr(4'd4, v);
    wr(4'd5, 32'd1);
    base_v = v; c0 = last_m + 1;
  endtask

  task automatic fire(input bit p, input bit r, input bit t, input logic [3:0] pins,
                      input logic [3:0] rm, input logic [15:0] rs, input logic [4:0] rp,
                      input logic [3:0] tm, input logic [15:0] ts, input logic [4:0] tp,
                      input bit expect_q, output int m);
    @(negedge clk);
    bus_wr = p; bus_addr = 4'd3; bus_wdata = 32'd1; hw_pin = pins;
    rx_stb = r; rx_msg = rm; rx_seq = rs; rx_port = rp;
    tx_stb = t; tx_msg = tm; tx_seq = ts; tx_port = tp;
    m = cyc;
    @(negedge clk);
    bus_wr = 1'b0; rx_stb = 1'b0; tx_stb = 1'b0;
    if (expect_q) begin
      if (p) mq.push_back({mk_hi(5'd0, 4'd0, 4'd0, 16'd0), stampf(m)});
      if (r) mq.push_back({mk_hi(rp, 4'd4, rm, rs), stampf(m)});
      if (t) mq.push_back({mk_hi(tp, 4'd5, tm, ts), stampf(m)});
    end
  endtask

  task automatic drain(input string req);
    logic [31:0] h, l;
    logic [63:0] e;
    repeat (6) @(negedge clk);
    while (mq.size() > 0) begin
      e = mq.pop_front();
      rd(4'd14, h); check({req, " head high"}, h, e[63:32]);
      rd(4'd13, l); check({req, " head stamp"}, l, e[31:0]);
      wr(4'd12, 32'd1);
    end
    rd(4'd8, h); check({req, " empty after drain"}, {31'd0, h[0]}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d);  check("R1 id word", d, IDW);
    rd(4'd1, d);  check("R1 control", d, 32'd0);
    rd(4'd8, d);  check("R1 raw status", d, 32'd0);
    rd(4'd14, d); check("R1 head high empty (R7)", d, 32'd0);
    rd(4'd13, d); check("R1 head stamp empty (R7)", d, 32'd0);
    check("R1 irq low", {31'd0, irq}, 32'd0);

    // R13 reference select
    wr(4'd2, 32'd21);
    check("R13 ref_sel", {27'd0, ref_sel}, 32'd21);

    // start counter from 0: R2 stamps follow the cycle count
    wr(4'd1, 32'h0000_0F01);
    base_v = '0; c0 = last_m + 1;

    // constrained random bursts of push / rx / tx (R3 R6 R8)
    for (int it = 0; it < 48; it++) begin
      int sel;
      sel = $urandom_range(1, 7);
      fire(sel[0], sel[1], sel[2], 4'd0,
           4'($urandom), 16'($urandom), 5'($urandom),
           4'($urandom), 16'($urandom), 5'($urandom), 1'b1, m);
      repeat (3 + $urandom_range(0, 5)) @(negedge clk);
      if (mq.size() >= 10 || it == 47) drain("R3 R6 R8 random");
    end

    // R4 wrap and R8 ordering: wrap lands on the same edge as a push
    load(32'hFFFF_FFFE);
    mq.push_back({mk_hi(5'd0, 4'd1, 4'd0, 16'd0), 32'd0});
    fire(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0, 5'd0, 4'd0, 16'd0, 5'd0, 1'b1, m);
    check("R4 push at all ones", stampf(m), 32'hFFFF_FFFF);
    drain("R4 R8 wrap");

    // R4 half point with push, rx and tx on the same edge (R8)
    load(32'h7FFF_FFFE);
    mq.push_back({mk_hi(5'd0, 4'd2, 4'd0, 16'd0), 32'h8000_0000});
    fire(1'b1, 1'b1, 1'b1, 4'd0, 4'd9, 16'hBEEF, 5'd3, 4'd2, 16'h1234, 5'd17, 1'b1, m);
    drain("R4 R8 half");

    // R5 disabled pin is ignored
    wr(4'd1, 32'h0000_0E01);
    fire(1'b0, 1'b0, 1'b0, 4'b0001, 4'd0, 16'd0, 5'd0, 4'd0, 16'd0, 5'd0, 1'b0, m);
    repeat (8) @(negedge clk);
    rd(4'd8, d); check("R5 disabled pin queues nothing", d, 32'd0);
    hw_pin = '0;
    wr(4'd1, 32'h0000_0F01);
    repeat (4) @(negedge clk);

    // R5 pin 3 and pin 4 rise together with a push
    fire(1'b1, 1'b0, 1'b0, 4'b1100, 4'd0, 16'd0, 5'd0, 4'd0, 16'd0, 5'd0, 1'b1, m);
    mq.push_back({mk_hi(5'd3, 4'd3, 4'd0, 16'd0), stampf(m) + 32'd2});
    mq.push_back({mk_hi(5'd4, 4'd3, 4'd0, 16'd0), stampf(m) + 32'd2});
    drain("R5 pins");
    hw_pin = '0;

    // R12 disabled unit queues nothing; R2 counter holds while disabled
    wr(4'd1, 32'h0000_0000);
    fire(1'b1, 1'b1, 1'b1, 4'd0, 4'd1, 16'd1, 5'd1, 4'd1, 16'd1, 5'd1, 1'b0, m);
    repeat (6) @(negedge clk);
    rd(4'd8, d); check("R12 nothing queued while off", d, 32'd0);
    wr(4'd4, 32'h0000_1000);
    wr(4'd5, 32'd1);
    repeat (10) @(negedge clk);
    wr(4'd1, 32'h0000_0001);
    base_v = 32'h0000_1000; c0 = last_m + 1;
    fire(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0, 5'd0, 4'd0, 16'd0, 5'd0, 1'b1, m);
    drain("R2 hold then run");

    // R10 overflow: 18 pushes into 16 entries
    for (int k = 0; k < 18; k++) begin
      fire(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0, 5'd0, 4'd0, 16'd0, 5'd0, (k < 16), m);
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(4'd8, d);  check("R10 overflow and pending", d, 32'd3);
    rd(4'd13, d); check("R10 oldest entry kept", d, mq[0][31:0]);
    drain("R9 R10 full queue");
    rd(4'd8, d);  check("R10 overflow sticky", d, 32'd2);
    wr(4'd12, 32'd1);
    rd(4'd14, d); check("R9 pop on empty", d, 32'd0);
    rd(4'd8, d);  check("R9 pop on empty keeps status", d, 32'd2);
    wr(4'd8, 32'd2);
    rd(4'd8, d);  check("R10 overflow cleared", d, 32'd0);

    // R11 interrupt masking and test bit
    fire(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0, 5'd0, 4'd0, 16'd0, 5'd0, 1'b1, m);
    repeat (4) @(negedge clk);
    rd(4'd9, d); check("R11 masked off", d, 32'd0);
    check("R11 irq masked", {31'd0, irq}, 32'd0);
    wr(4'd10, 32'd1);
    rd(4'd9, d); check("R11 masked on", d, 32'd1);
    check("R11 irq on", {31'd0, irq}, 32'd1);
    drain("R11 drain");
    check("R11 irq off when empty", {31'd0, irq}, 32'd0);
    wr(4'd1, 32'h0000_0003);
    rd(4'd8, d); check("R11 test bit raw", d, 32'd1);
    check("R11 test bit irq", {31'd0, irq}, 32'd1);
    wr(4'd1, 32'h0000_0001);
    rd(4'd8, d); check("R11 test bit cleared", d, 32'd0);

    finish_run();
  end
endmodule